// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A free-running strobe at sixteen times the bit rate paces the line. An 8-bit format word chooses the character length (5 to 8 bits), whether a parity bit is sent and of what kind, and how long the stop period lasts. A separate bit in the same word forces the line low to send a break.

Bytes enter through a valid/ready port backed by a one-entry holding register. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the holding register is full. The sender keeps `in_valid`, `in_data` and the wanted format on `line_cfg` steady until that edge. `in_ready` also serves as the holding-empty flag: it rises on the same edge that moves the byte into the shifter. The format word is captured together with the byte. `busy` marks the frame in flight.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight and break is off, `txd` is 1 and `busy` is 0. After reset `in_ready` is 1.
- R2: A byte is accepted on a clock edge with `in_valid` and `in_ready` both high. `in_ready` then stays low until the edge that moves the byte into the shifter, and that same edge raises `busy`. While `in_ready` is low, `in_valid` has no effect.
- R3: A frame is a start bit at 0, then the data bits with the least significant bit first, then the optional parity bit, then the stop period at 1. Every start, data and parity bit lasts 16 `baud_tick` strobes.
- R4: `line_cfg[1:0]` sets the data bits per character: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Byte bits above the chosen length are never sent.
- R5: `line_cfg[3]`=1 puts one parity bit between the last data bit and the stop period. `line_cfg[3]`=0 sends none.
- R6: With parity on and `line_cfg[5]`=0, `line_cfg[4]`=1 makes the count of ones over the data bits and the parity bit even, and `line_cfg[4]`=0 makes it odd.
- R7: With parity on and `line_cfg[5]`=1, the parity bit is the inverse of `line_cfg[4]`, whatever the data.
- R8: With `line_cfg[2]`=0 the stop period is 16 ticks. With `line_cfg[2]`=1 it is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R9: While the live `line_cfg[6]` is 1, `txd` is 0, both idle and mid-frame. Frame timing carries on underneath and the line returns to its normal value when the bit clears.
- R10: The format bits [5:0] are taken at the moment of acceptance. Later changes to them do not alter that character.
- R11: `busy` stays high from the start bit until the stop period ends. A byte waiting in the holding register starts its frame on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| line_cfg | input | 8 | Format word; bit 6 is break and acts live |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding register empty; byte taken when high with in_valid |
| busy | output | 1 | Frame in flight |
| txd | output | 1 | Serial line, idles at 1 |

## Verification
The bench builds the block with the default oversampling of 16. That makes the half stop bit an exact 8-tick span, so the 24-tick stop period of a 5-bit character can be told apart from the 16- and 32-tick ones. The tick strobe comes every fourth clock, which keeps frames short enough to cover every word length, every parity kind and both stop settings. It also leaves room for idle clocks between ticks, where an off-by-one in the hand-off from holding register to shifter would show up as a shifted edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [7:0] cfg);
    fmt_t f;
    f.wlen      = cfg[1:0];
    f.long_stop = cfg[2];
    f.par_en    = cfg[3];
    f.even      = cfg[4];
    f.stick     = cfg[5];
    return f;
  endfunction

  function automatic logic [3:0] word_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  function automatic logic [7:0] word_mask(input logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  function automatic logic parity_of(input logic [7:0] data, input fmt_t f);
    logic [7:0] used;
    used = data & word_mask(f.wlen);
    if (f.stick) return ~f.even;
    return f.even ? ^used : ~^used;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  fmt_t              in_fmt,
  input  logic              take,
  output logic              in_ready,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output fmt_t              hold_fmt
);

  logic accept;

  assign in_ready = ~hold_valid;
  assign accept   = in_valid & ~hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_fmt   <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_data  <= in_data;
      hold_fmt   <= in_fmt;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold_valid,
  input  logic [7:0] hold_data,
  input  fmt_t       hold_fmt,
  output logic       take,
  output logic       busy,
  output logic       line
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam logic [CNT_W-1:0] BIT_LEN   = CNT_W'(OVERSAMPLE);
  localparam logic [CNT_W-1:0] STOP_MID  = CNT_W'(OVERSAMPLE + HALF);
  localparam logic [CNT_W-1:0] STOP_LONG = CNT_W'(2 * OVERSAMPLE);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } st_t;

  st_t              st;
  logic [7:0]       sh;
  logic [2:0]       idx;
  logic [CNT_W-1:0] tcnt;
  fmt_t             fmt_q;
  logic             par_q;
  logic [CNT_W-1:0] stop_len;
  logic [CNT_W-1:0] limit;
  logic             bit_done;
  logic             last_data;

  always_comb begin
    if (!fmt_q.long_stop)     stop_len = BIT_LEN;
    else if (fmt_q.wlen == 0) stop_len = STOP_MID;
    else                      stop_len = STOP_LONG;
  end

  assign limit     = (st == ST_STOP) ? stop_len : BIT_LEN;
  assign bit_done  = tick && (tcnt == limit - 1'b1);
  assign last_data = ({1'b0, idx} == word_bits(fmt_q.wlen) - 4'd1);
  assign take      = (st == ST_IDLE) && hold_valid;
  assign busy      = (st != ST_IDLE);

  always_comb begin
    unique case (st)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      sh    <= '0;
      idx   <= '0;
      tcnt  <= '0;
      fmt_q <= '0;
      par_q <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (hold_valid) begin
        st    <= ST_START;
        sh    <= hold_data;
        fmt_q <= hold_fmt;
        par_q <= parity_of(hold_data, hold_fmt);
        idx   <= '0;
        tcnt  <= '0;
      end
    end else if (tick) begin
      if (!bit_done) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (st)
          ST_START: begin
            st  <= ST_DATA;
            idx <= '0;
          end
          ST_DATA: begin
            sh <= {1'b0, sh[7:1]};
            if (last_data) st <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else           idx <= idx + 1'b1;
          end
          ST_PAR:  st <= ST_STOP;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sertx_drive.sv
module sertx_drive (
  input  logic brk,
  input  logic line,
  output logic txd
);

  assign txd = brk ? 1'b0 : line;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] line_cfg,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       busy,
  output logic       txd
);

  logic       take;
  logic       hold_valid;
  logic [7:0] hold_data;
  fmt_t       hold_fmt;
  logic       line;

  sertx_hold #(.DATA_W(8)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_fmt     (decode_fmt(line_cfg)),
    .take       (take),
    .in_ready   (in_ready),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .hold_fmt   (hold_fmt)
  );

  sertx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .hold_fmt   (hold_fmt),
    .take       (take),
    .busy       (busy),
    .line       (line)
  );

  sertx_drive u_drive (
    .brk  (line_cfg[6]),
    .line (line),
    .txd  (txd)
  );

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] line_cfg,
  input logic       in_valid,
  input logic       in_ready,
  input logic       busy,
  input logic       txd
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_cfg[6]) |-> txd);

  // R2
  accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  handoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> in_ready);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !line_cfg[6]) |-> !txd);

  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_cfg[6] |-> !txd);

  // R11
  waiting_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !busy) |=> busy);

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_cfg (line_cfg),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .txd      (txd)
);

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;

  localparam int OS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] line_cfg = 8'h03;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       busy;
  logic       txd;

  int    checks = 0;
  int    errors = 0;
  int    tdiv = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  bit         m_full = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic [7:0] m_cfg = 8'h00;
  bit         q[$];

  always #10 clk = ~clk;

  serial_frame_tx #(.OVERSAMPLE(OS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .line_cfg  (line_cfg),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .busy      (busy),
    .txd       (txd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void push_level(input bit lvl, input int n);
    for (int k = 0; k < n; k++) q.push_back(lvl);
  endfunction

  function automatic void build_frame(input logic [7:0] d, input logic [7:0] c);
    int n;
    int ones;
    bit p;
    n = 5 + int'(c[1:0]);
    ones = 0;
    push_level(1'b0, OS);
    for (int i = 0; i < n; i++) begin
      push_level(d[i], OS);
      if (d[i]) ones++;
    end
    if (c[3]) begin
      if (c[5]) p = ~c[4];
      else      p = c[4] ? (ones % 2 == 1) : (ones % 2 == 0);
      push_level(p, OS);
    end
    if (!c[2])      push_level(1'b1, OS);
    else if (n == 5) push_level(1'b1, OS + OS / 2);
    else            push_level(1'b1, 2 * OS);
  endfunction

  always @(posedge clk) begin
    bit was_idle;
    bit was_full;
    if (!rst_n) begin
      m_full = 1'b0;
      q.delete();
    end else begin
      was_idle = (q.size() == 0);
      was_full = m_full;
      if (!was_idle) begin
        if (baud_tick) void'(q.pop_front());
      end else if (was_full) begin
        build_frame(m_data, m_cfg);
        m_full = 1'b0;
      end
      if (!was_full && in_valid) begin
        m_full = 1'b1;
        m_data = in_data;
        m_cfg  = line_cfg;
      end
    end
  end

  always @(posedge clk) begin
    bit eb;
    bit et;
    #15;
    if (rst_n && cmp_on) begin
      eb = (q.size() != 0);
      et = line_cfg[6] ? 1'b0 : (eb ? q[0] : 1'b1);
      chk(cur_req, "txd", int'(txd), int'(et));
      chk(cur_req, "busy", int'(busy), int'(eb));
      chk(cur_req, "in_ready", int'(in_ready), int'(!m_full));
    end
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 0);
  end

  task automatic send(input logic [7:0] d, input logic [7:0] c);
    @(negedge clk);
    line_cfg = c;
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !in_ready) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset txd", int'(txd), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R3";
    send(8'hA5, 8'h03); wait_idle();
    send(8'h3C, 8'h03); wait_idle();

    cur_req = "R4";
    send(8'hE3, 8'h00); wait_idle();
    send(8'hD6, 8'h01); wait_idle();
    send(8'hB9, 8'h02); wait_idle();

    cur_req = "R5";
    send(8'h00, 8'h0A); wait_idle();
    send(8'h71, 8'h03); wait_idle();

    cur_req = "R6";
    send(8'h5A, 8'h0B); wait_idle();
    send(8'h5B, 8'h1B); wait_idle();
    send(8'hF7, 8'h08); wait_idle();

    cur_req = "R7";
    send(8'h5B, 8'h2B); wait_idle();
    send(8'h5A, 8'h3B); wait_idle();

    cur_req = "R8";
    send(8'h15, 8'h04); wait_idle();
    send(8'h2A, 8'h05); wait_idle();
    send(8'hC3, 8'h07); wait_idle();

    cur_req = "R10";
    send(8'h96, 8'h1F);
    line_cfg = 8'h24;
    wait_idle();

    cur_req = "R2";
    send(8'h11, 8'h03);
    send(8'h22, 8'h0C);
    send(8'h33, 8'h3D);
    cur_req = "R11";
    wait_idle();

    cur_req = "R9";
    line_cfg = 8'h43;
    repeat (20) @(negedge clk);
    line_cfg = 8'h03;
    send(8'h81, 8'h03);
    repeat (150) @(negedge clk);
    line_cfg = 8'h43;
    repeat (200) @(negedge clk);
    line_cfg = 8'h03;
    wait_idle();

    cur_req = "R1";
    chk("R1", "final txd", int'(txd), 1);
    chk("R1", "final busy", int'(busy), 0);
    finish_run();
  end

endmodule